// File: doc/BRIEF.md
# Latched Wait Gate

A per-thread pipeline stage that sits between the instruction stream and backend dispatch. A side port installs a wait record, decoded from either a stall-wait word (opcode 0xA2) or a semaphore-wait word (opcode 0xA6). While the record is latched, the stage re-evaluates the selected conditions every cycle. A stall-wait checks a 13-bit status vector. A semaphore-wait checks per-semaphore "zero" and "at max" flags.

While a wait is latched, any instruction whose category bits meet the 9-bit block mask is held at the head of the stream. Nothing behind it moves until the wait releases. With no wait latched the stage is a combinational pass-through.

Each thread instantiates its own copy. A new wait word always replaces the latched one.

Top module: `wait_gate`

## Requirements
- R1: After reset no wait is latched: `stalled_o` is 0 and every presented instruction reaches the output in the same cycle.
- R2: Stall-wait word: opcode 0xA2 in bits [31:24], block mask in [23:15], condition mask in [12:0]. While it is latched, condition bit i set and `stat_i[i]` = 1 keeps the wait alive. This holds for every i from 0 to 12, including bit 9 and bit 12.
- R3: Semaphore-wait word: opcode 0xA6 in bits [31:24], block mask in [23:15], semaphore select in [14:2], condition in [1:0]. Select bit j observes semaphore j. Condition bit 0 keeps waiting while a selected `sem_zero_i` is 1. Condition bit 1 keeps waiting while a selected `sem_full_i` is 1. Unselected semaphores, and flags whose condition bit is clear, have no effect.
- R4: A block mask field of 0 is used as 0x040. A stall-wait condition field of 0 is used as 0x00F.
- R5: The wait releases on the clock edge that ends the first cycle in which no selected condition is true. The block lifts one cycle after the condition clears, so a matching instruction presented right after installation is held for at least one cycle.
- R6: While latched, instructions that do not match pass in order. The first matching instruction is held, and nothing passes until release. Payloads leave in the order they entered.
- R7: A NOP instruction (`in_kind_i` = 2'b01) is held only when all nine block mask bits are set.
- R8: A sync-class instruction (`in_kind_i` = 2'b10) is held by any non-zero block mask, whatever its category bits. For plain instructions (`in_kind_i` = 2'b00 or 2'b11), a match means `in_cat_i` AND block mask is non-zero.
- R9: With no wait latched, `out_valid_o` equals `in_valid_i` and `in_ready_o` equals `out_ready_i` in the same cycle.
- R10: A wait word accepted while a wait is latched replaces the whole record and clears the held state. Only the new mask and conditions apply from the next cycle.
- R11: A semaphore-wait with condition field 0 counts as satisfied and releases after the minimum one-cycle hold.
- R12: A word on the install port whose opcode is neither 0xA2 nor 0xA6 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_valid_i | input | 1 | Wait word present on the install port |
| wait_word_i | input | 32 | Stall-wait or semaphore-wait instruction word |
| stat_i | input | 13 | Status flags, 1 = keep waiting, one per condition bit |
| sem_zero_i | input | NSEM | Semaphore j value is zero |
| sem_full_i | input | NSEM | Semaphore j value is at or above its max |
| in_valid_i | input | 1 | Upstream instruction valid |
| in_ready_o | output | 1 | Upstream instruction accepted |
| in_data_i | input | DW | Instruction payload |
| in_kind_i | input | 2 | Class: 00 plain, 01 NOP, 10 sync, 11 plain |
| in_cat_i | input | 9 | Category bits of a plain instruction |
| out_valid_o | output | 1 | Dispatch valid |
| out_ready_i | input | 1 | Dispatch ready |
| out_data_o | output | DW | Dispatched payload |
| stalled_o | output | 1 | An instruction is being held by the gate |

## Verification
Two events can land on the same clock edge: a wait condition clearing, and a matching instruction sitting at the head of the stream. The bench provokes this by dropping the relevant status or semaphore flag on the same cycle a held instruction is present. It then requires `out_valid_o` to stay low in that cycle and rise in the next. Installation is also made to coincide with an already satisfied condition. In that case the first matching instruction must be held for exactly one cycle. A second word is installed over a live one, and the old mask must stop blocking from the next cycle.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int OPW  = 8;
  localparam int BLKW = 9;
  localparam int CNDW = 13;
  localparam int SELW = 13;
  localparam int SCW  = 2;
  localparam int WW   = 32;

  localparam int OP_LSB  = 24;
  localparam int BLK_LSB = 15;
  localparam int SEL_LSB = 2;

  localparam logic [OPW-1:0]  OP_STALL = 8'hA2;
  localparam logic [OPW-1:0]  OP_SEM   = 8'hA6;
  localparam logic [BLKW-1:0] BLK_DFLT = 9'h040;
  localparam logic [CNDW-1:0] CND_DFLT = 13'h00F;

  typedef enum logic [1:0] {
    K_PLAIN = 2'b00,
    K_NOP   = 2'b01,
    K_SYNC  = 2'b10,
    K_ALT   = 2'b11
  } kind_e;

  typedef struct packed {
    logic            is_sem;
    logic [BLKW-1:0] blk;
    logic [CNDW-1:0] cnd;
    logic [SELW-1:0] sel;
    logic [SCW-1:0]  scnd;
  } wait_rec_t;
endpackage

// File: rtl/wg_decode.sv
module wg_decode
  import wg_pkg::*;
(
  input  logic          valid_i,
  input  logic [WW-1:0] word_i,
  output logic          ok_o,
  output wait_rec_t     rec_o
);
  logic [OPW-1:0]  op;
  logic [BLKW-1:0] blk_raw;
  logic [CNDW-1:0] cnd_raw;
  logic            is_stall, is_sem;

  assign op      = word_i[OP_LSB +: OPW];
  assign blk_raw = word_i[BLK_LSB +: BLKW];
  assign cnd_raw = word_i[CNDW-1:0];

  always_comb begin
    is_stall     = (op == OP_STALL);
    is_sem       = (op == OP_SEM);
    ok_o         = valid_i && (is_stall || is_sem);
    rec_o.is_sem = is_sem;
    rec_o.blk    = (blk_raw == '0) ? BLK_DFLT : blk_raw;
    rec_o.cnd    = is_stall ? ((cnd_raw == '0) ? CND_DFLT : cnd_raw) : '0;
    rec_o.sel    = is_sem ? word_i[SEL_LSB +: SELW] : '0;
    rec_o.scnd   = is_sem ? word_i[SCW-1:0] : '0;
  end
endmodule

// File: rtl/wg_cond_eval.sv
module wg_cond_eval
  import wg_pkg::*;
#(
  parameter int NSEM = 8
) (
  input  wait_rec_t       rec_i,
  input  logic [CNDW-1:0] stat_i,
  input  logic [NSEM-1:0] sem_zero_i,
  input  logic [NSEM-1:0] sem_full_i,
  output logic            keep_o
);
  logic [CNDW-1:0] c_hit;
  logic [NSEM-1:0] s_hit;

  for (genvar i = 0; i < CNDW; i++) begin : g_cnd
    assign c_hit[i] = rec_i.cnd[i] & stat_i[i];
  end

  for (genvar j = 0; j < NSEM; j++) begin : g_sem
    assign s_hit[j] = rec_i.sel[j] &
                      ((rec_i.scnd[0] & sem_zero_i[j]) | (rec_i.scnd[1] & sem_full_i[j]));
  end

  if (NSEM < SELW) begin : g_sel_pad
    logic unused_sel;
    assign unused_sel = ^rec_i.sel[SELW-1:NSEM];
  end

  assign keep_o = rec_i.is_sem ? |s_hit : |c_hit;
endmodule

// File: rtl/wg_match.sv
module wg_match
  import wg_pkg::*;
(
  input  logic [BLKW-1:0] blk_i,
  input  logic [1:0]      kind_i,
  input  logic [BLKW-1:0] cat_i,
  output logic            hit_o
);
  always_comb begin
    unique case (kind_e'(kind_i))
      K_NOP:   hit_o = &blk_i;
      K_SYNC:  hit_o = |blk_i;
      default: hit_o = |(blk_i & cat_i);
    endcase
  end
endmodule

// File: rtl/wait_gate.sv
module wait_gate
  import wg_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NSEM = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wait_valid_i,
  input  logic [WW-1:0]   wait_word_i,
  input  logic [CNDW-1:0] stat_i,
  input  logic [NSEM-1:0] sem_zero_i,
  input  logic [NSEM-1:0] sem_full_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [DW-1:0]   in_data_i,
  input  logic [1:0]      in_kind_i,
  input  logic [BLKW-1:0] in_cat_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [DW-1:0]   out_data_o,
  output logic            stalled_o
);
  wait_rec_t dec_rec, rec_q;
  logic      inst_fire, keep, hit, hold;
  logic      active_q, held_q;

  wg_decode u_dec (
    .valid_i (wait_valid_i),
    .word_i  (wait_word_i),
    .ok_o    (inst_fire),
    .rec_o   (dec_rec)
  );

  wg_cond_eval #(.NSEM(NSEM)) u_eval (
    .rec_i      (rec_q),
    .stat_i     (stat_i),
    .sem_zero_i (sem_zero_i),
    .sem_full_i (sem_full_i),
    .keep_o     (keep)
  );

  wg_match u_match (
    .blk_i  (rec_q.blk),
    .kind_i (in_kind_i),
    .cat_i  (in_cat_i),
    .hit_o  (hit)
  );

  // install wins over release; release is registered, giving the one-cycle lag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      held_q   <= 1'b0;
      rec_q    <= '0;
    end else if (inst_fire) begin
      active_q <= 1'b1;
      held_q   <= 1'b0;
      rec_q    <= dec_rec;
    end else if (active_q && !keep) begin
      active_q <= 1'b0;
      held_q   <= 1'b0;
    end else if (active_q && in_valid_i && hit) begin
      held_q   <= 1'b1;
    end
  end

  // once a match is held the whole stream stops, not only its category
  assign hold        = active_q && (held_q || hit);
  assign out_valid_o = in_valid_i && !hold;
  assign in_ready_o  = out_ready_i && !hold;
  assign out_data_o  = in_data_i;
  assign stalled_o   = in_valid_i && hold;

  a_r5_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_fire |=> active_q);

  a_r5_release_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !keep && !inst_fire) |=> !active_q);

  a_r5_stay_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && keep && !inst_fire) |=> active_q);

  a_r6_match_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && in_valid_i && hit) |-> (!out_valid_o && !in_ready_o));

  a_r6_held_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && keep && !inst_fire) |=> held_q);

  a_r7_nop_partial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && in_valid_i && kind_e'(in_kind_i) == K_NOP && rec_q.blk != '1) |-> out_valid_o);

  a_r9_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (out_valid_o == in_valid_i && in_ready_o == out_ready_i));

  a_r10_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_fire |=> !held_q);
endmodule

// File: tb/wait_gate_test.sv
module wait_gate_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wait_valid_i = 1'b0;
  logic [31:0] wait_word_i = '0;
  logic [12:0] stat_i = '0;
  logic [7:0]  sem_zero_i = '0;
  logic [7:0]  sem_full_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic [1:0]  in_kind_i = '0;
  logic [8:0]  in_cat_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_data_o;
  logic        stalled_o;

  int checks = 0;
  int errors = 0;
  int pay = 0;
  bit done = 0;
  logic [31:0] expq[$];

  always #2.5 clk = ~clk;

  wait_gate uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wait_valid_i(wait_valid_i), .wait_word_i(wait_word_i),
    .stat_i(stat_i), .sem_zero_i(sem_zero_i), .sem_full_i(sem_full_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .in_kind_i(in_kind_i), .in_cat_i(in_cat_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .stalled_o(stalled_o)
  );

  function automatic logic [31:0] sw(logic [8:0] blk, logic [12:0] cnd);
    return {8'hA2, blk, 2'b00, cnd};
  endfunction

  function automatic logic [31:0] smw(logic [8:0] blk, logic [12:0] sel, logic [1:0] c);
    return {8'hA6, blk, sel, c};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic install(logic [31:0] w);
    tick();
    in_valid_i   = 1'b0;
    wait_valid_i = 1'b1;
    wait_word_i  = w;
    tick();
    wait_valid_i = 1'b0;
  endtask

  task automatic present(logic [1:0] k, logic [8:0] c);
    pay++;
    in_valid_i = 1'b1;
    in_data_i  = 32'hC000_0000 + pay;
    in_kind_i  = k;
    in_cat_i   = c;
  endtask

  task automatic look(bit exp, string tag);
    #1;
    chk(out_valid_o == exp, tag, out_valid_o, exp);
    chk(stalled_o == (in_valid_i && !exp), {tag, " stalled"}, stalled_o, in_valid_i && !exp);
    if (exp && in_valid_i && out_ready_i) expq.push_back(in_data_i);
  endtask

  // scoreboard monitor: pops expected payloads as dispatches happen
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_ni && out_valid_o && out_ready_i) begin
        if (expq.size() == 0) chk(0, "R6 unexpected dispatch", out_data_o, 0);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          chk(out_data_o == e, "R6 dispatch order", out_data_o, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R1 / R9
    present(2'b00, 9'h040); look(1, "R1 reset passthrough");
    tick(); out_ready_i = 1'b0; present(2'b10, 9'h000);
    #1; chk(in_ready_o == 1'b0, "R9 ready follows downstream", in_ready_o, 0);
    chk(out_valid_o == 1'b1, "R9 valid follows upstream", out_valid_o, 1);
    tick(); out_ready_i = 1'b1; look(1, "R9 passthrough");
    tick(); in_valid_i = 1'b0;

    // R2 / R6: C4 with block B6
    stat_i = 13'h0010;
    install(sw(9'h040, 13'h0010));
    present(2'b00, 9'h001); look(1, "R6 non-matching passes");
    tick(); present(2'b00, 9'h040); look(0, "R2 held on C4");
    tick(); stat_i = '0; look(0, "R5 lag after clear");
    tick(); look(1, "R5 released");
    tick(); in_valid_i = 1'b0;

    // R2: C9 and C12
    install(sw(9'h040, 13'h1200));
    stat_i = 13'h0200; present(2'b00, 9'h040); look(0, "R2 held on C9");
    tick(); stat_i = 13'h1000; look(0, "R2 held on C12");
    tick(); stat_i = '0; look(0, "R2 lag");
    tick(); look(1, "R2 released");
    tick(); in_valid_i = 1'b0;

    // R5: already satisfied condition, minimum hold
    install(sw(9'h1FF, 13'h0001));
    present(2'b00, 9'h001); look(0, "R5 min hold");
    tick(); look(1, "R5 min hold release");
    tick(); in_valid_i = 1'b0;

    // R4: default block and condition masks
    install(32'hA200_0000);
    stat_i = 13'h0004; present(2'b00, 9'h080); look(1, "R4 default block spares B7");
    tick(); present(2'b00, 9'h040); look(0, "R4 default block holds B6");
    tick(); stat_i = 13'h0030; look(0, "R4 lag");
    tick(); look(1, "R4 default cond ignores C4 C5");
    tick(); in_valid_i = 1'b0; stat_i = '0;

    // R7 / R8
    stat_i = 13'h0001;
    install(sw(9'h080, 13'h0001));
    present(2'b01, 9'h000); look(1, "R7 nop passes partial mask");
    tick(); present(2'b10, 9'h000); look(0, "R8 sync held by any bit");
    tick(); stat_i = '0; look(0, "R8 lag");
    tick(); look(1, "R8 released");
    tick(); in_valid_i = 1'b0;
    stat_i = 13'h0001;
    install(sw(9'h1FF, 13'h0001));
    present(2'b01, 9'h000); look(0, "R7 nop held full mask");
    tick(); stat_i = '0; look(0, "R7 lag");
    tick(); look(1, "R7 released");
    tick(); in_valid_i = 1'b0;

    // R3: semaphore zero, then max
    sem_zero_i = 8'h03;
    install(smw(9'h001, 13'h0002, 2'b01));
    present(2'b00, 9'h001); look(0, "R3 held on zero");
    tick(); sem_zero_i = 8'h01; look(0, "R3 lag");
    tick(); look(1, "R3 unselected zero ignored");
    tick(); in_valid_i = 1'b0;
    sem_zero_i = 8'hFF; sem_full_i = 8'h02;
    install(smw(9'h001, 13'h0002, 2'b10));
    present(2'b00, 9'h001); look(0, "R3 held at max");
    tick(); sem_full_i = '0; look(0, "R3 max lag");
    tick(); look(1, "R3 zero ignored under max only");
    tick(); in_valid_i = 1'b0;

    // R11: semaphore condition field 0
    sem_full_i = 8'hFF;
    install(smw(9'h001, 13'h00FF, 2'b00));
    present(2'b00, 9'h001); look(0, "R11 min hold");
    tick(); look(1, "R11 release");
    tick(); in_valid_i = 1'b0; sem_zero_i = '0; sem_full_i = '0;

    // R10: overwrite a live wait
    stat_i = 13'h0011;
    install(sw(9'h040, 13'h0010));
    install(sw(9'h080, 13'h0001));
    present(2'b00, 9'h040); look(1, "R10 old mask gone");
    tick(); present(2'b00, 9'h080); look(0, "R10 new mask holds");
    tick(); stat_i = 13'h0010; look(0, "R10 lag");
    tick(); look(1, "R10 new condition governs");
    tick(); in_valid_i = 1'b0; stat_i = '0;

    // R12: foreign opcode ignored
    stat_i = 13'h1FFF;
    install(32'h55FF_FFFF);
    present(2'b00, 9'h1FF); look(1, "R12 foreign opcode ignored");
    tick(); in_valid_i = 1'b0; stat_i = '0;

    repeat (3) tick();
    chk(expq.size() == 0, "R6 all payloads delivered", expq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule